// File: doc/BRIEF.md
# Eight-Bit Multicycle Register-Compare CPU

This block is a small multicycle processor with four 8-bit general registers, a 16-bit instruction pointer and a 16-bit return pointer. It runs a sixteen-opcode instruction set through one byte-wide synchronous memory port and moves one byte per clock. There is no flags register. Conditional branches and calls compare two general registers directly. A call stores its return address on a stack in memory that grows downwards and starts just below the device window at the top of the address space.

Memory contents, program loading and device models sit outside the block. After reset the core waits with the bus quiet until `start` is seen high, so a loader can fill memory first. Devices in the top sixteen addresses, including the character terminal at FFFF, are reached through ordinary load and store cycles. A HALT instruction parks the core until the next reset.

Top module: `byte_cpu`

## Requirements
- R1: Reset sets IP to 0000 and RP to FFF0. The general registers are not reset. While `start` is low after reset, neither `mem_re` nor `mem_we` is asserted. The first fetch, a read at 0000, appears in the cycle after the edge that samples `start` high.
- R2: Bits 7:4 of an instruction byte are the opcode, bits 3:2 select RX and bits 1:0 select RY. Opcodes A to F are three bytes long: the opcode byte, then the address high byte, then the address low byte, read from consecutive addresses.
- R3: Read data on `mem_rdata` is taken one cycle after the read is presented. Each instruction uses a fixed number of cycles, the first always being a fetch read at IP, after which IP advances. Opcodes 2 to 9 take 2 cycles. HALT, RET, STORE, branches and not-taken calls take 2, 4, 4, 4 and 4 cycles. LOAD and taken calls take 5.
- R4: Opcode 2 shifts RX left by one and opcode 3 shifts it right by one. Both fill the vacated bit with zero.
- R5: Opcode 4 rotates RX left by one and opcode 5 rotates it right by one. The bit shifted out re-enters at the opposite end.
- R6: Opcodes 6, 7, 8 and 9 replace RX with RX NAND RY, RX AND RY, RX OR RY and RX XOR RY.
- R7: Opcode A reads the addressed byte into RX. Opcode B writes RX to the address. Address FFFF is the terminal and uses the same read and write cycles.
- R8: Opcode C jumps to the address when RX equals RY, and opcode D jumps when they differ. If the branch is not taken, execution continues after the three bytes.
- R9: Opcode E (taken on equal) and opcode F (taken on unequal) perform a call. A taken call subtracts 2 from RP, writes the return address high byte at RP and the low byte at RP+1 in consecutive cycles, then jumps. The return address is the byte after the call.
- R10: Opcode 1 reads the IP high byte at RP and the low byte at RP+1, then adds 2 to RP.
- R11: Opcode 0 raises `halted` in the cycle after its fetch completes. After that there are no further bus cycles and `start` has no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Leave the post-reset idle state |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after the read |
| halted | output | 1 | Core has executed HALT |

## Verification
The bench targets the cases where the cycle order matters. A wrong stack order would show up as a return address written at FFEF before FFEE, or as a push that skips the decrement. Saving IP too early would make a call return into its own address bytes. A nested call must push below the first frame and return in the right order, and a design that mixes up RET's high and low bytes would jump to a swapped address. The bench also tests both outcomes of every compare opcode, rotate versus shift at the edge bits (0x81, 0x96), and terminal reads and writes at FFFF. A core that mixed these up would show a wrong write byte or a branch going the wrong way.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

    localparam int DW     = 8;
    localparam int AW     = 16;
    localparam int NREG   = 4;
    localparam int RSEL_W = $clog2(NREG);
    localparam int OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'h0,
        OP_RET   = 4'h1,
        OP_SHL   = 4'h2,
        OP_SHR   = 4'h3,
        OP_ROL   = 4'h4,
        OP_ROR   = 4'h5,
        OP_NAND  = 4'h6,
        OP_AND   = 4'h7,
        OP_OR    = 4'h8,
        OP_XOR   = 4'h9,
        OP_LOAD  = 4'hA,
        OP_STORE = 4'hB,
        OP_BREQ  = 4'hC,
        OP_BRNE  = 4'hD,
        OP_CLEQ  = 4'hE,
        OP_CLNE  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_ADR_HI,
        S_ADR_LO,
        S_LOAD_WB,
        S_PUSH_LO,
        S_RET_HI,
        S_RET_LO,
        S_HALT
    } state_e;

    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   ip;
        logic [AW-1:0]   rp;
        logic [DW-1:0]   ir;
        logic [DW-1:0]   tmp;
        logic [AW-1:0]   tgt;
    } core_t;

endpackage

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
    import byte_cpu_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic [OPC_W-1:0] op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             eq
);

    always_comb begin
        unique case (opcode_e'(op))
            OP_SHL:  y = {a[WIDTH-2:0], 1'b0};
            OP_SHR:  y = {1'b0, a[WIDTH-1:1]};
            OP_ROL:  y = {a[WIDTH-2:0], a[WIDTH-1]};
            OP_ROR:  y = {a[0], a[WIDTH-1:1]};
            OP_NAND: y = ~(a & b);
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end

    assign eq = (a == b);

endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
    parameter int N     = 4,
    parameter int WIDTH = 8,
    localparam int SW   = $clog2(N)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [SW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [SW-1:0]    raddr_a,
    input  logic [SW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] regs_q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we && (waddr == SW'(i))) begin
                regs_q[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
    import byte_cpu_pkg::*;
#(
    parameter logic [15:0] IP_RESET = 16'h0000,
    parameter logic [15:0] RP_RESET = 16'hFFF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic        halted
);

    core_t core_d, core_q;

    logic [DW-1:0]     dec_byte;
    opcode_e           dec_op;
    logic [RSEL_W-1:0] rx_f, ry_f;
    logic [DW-1:0]     rx_val, ry_val, alu_y;
    logic              regs_eq;
    logic              rf_we;
    logic [RSEL_W-1:0] rf_waddr;
    logic [DW-1:0]     rf_wdata;
    logic [AW-1:0]     tgt_now;
    logic              cond_hit;

    // In DECODE the opcode byte is still on the read bus; afterwards it is held in ir.
    assign dec_byte = (core_q.st == S_DECODE) ? mem_rdata : core_q.ir;
    assign dec_op   = opcode_e'(dec_byte[7:4]);
    assign rx_f     = dec_byte[3:2];
    assign ry_f     = dec_byte[1:0];
    assign tgt_now  = {core_q.tmp, mem_rdata};
    assign cond_hit = regs_eq ^ dec_byte[4];

    byte_cpu_regfile #(.N(NREG), .WIDTH(DW)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rx_f),
        .raddr_b (ry_f),
        .rdata_a (rx_val),
        .rdata_b (ry_val)
    );

    byte_cpu_alu #(.WIDTH(DW)) u_alu (
        .op (dec_byte[7:4]),
        .a  (rx_val),
        .b  (ry_val),
        .y  (alu_y),
        .eq (regs_eq)
    );

    always_comb begin
        core_d    = core_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rf_we     = 1'b0;
        rf_waddr  = rx_f;
        rf_wdata  = alu_y;

        unique case (core_q.st)
            S_IDLE: begin
                if (start) core_d.st = S_FETCH;
            end
            S_FETCH: begin
                mem_re    = 1'b1;
                mem_addr  = core_q.ip;
                core_d.ip = core_q.ip + 16'd1;
                core_d.st = S_DECODE;
            end
            S_DECODE: begin
                core_d.ir = mem_rdata;
                unique case (dec_op)
                    OP_HALT: core_d.st = S_HALT;
                    OP_RET: begin
                        mem_re    = 1'b1;
                        mem_addr  = core_q.rp;
                        core_d.st = S_RET_HI;
                    end
                    OP_SHL, OP_SHR, OP_ROL, OP_ROR,
                    OP_NAND, OP_AND, OP_OR, OP_XOR: begin
                        rf_we     = 1'b1;
                        core_d.st = S_FETCH;
                    end
                    default: begin
                        mem_re    = 1'b1;
                        mem_addr  = core_q.ip;
                        core_d.ip = core_q.ip + 16'd1;
                        core_d.st = S_ADR_HI;
                    end
                endcase
            end
            S_ADR_HI: begin
                core_d.tmp = mem_rdata;
                mem_re     = 1'b1;
                mem_addr   = core_q.ip;
                core_d.ip  = core_q.ip + 16'd1;
                core_d.st  = S_ADR_LO;
            end
            S_ADR_LO: begin
                core_d.st = S_FETCH;
                unique case (dec_op)
                    OP_LOAD: begin
                        mem_re    = 1'b1;
                        mem_addr  = tgt_now;
                        core_d.st = S_LOAD_WB;
                    end
                    OP_STORE: begin
                        mem_we    = 1'b1;
                        mem_addr  = tgt_now;
                        mem_wdata = rx_val;
                    end
                    OP_BREQ, OP_BRNE: begin
                        if (cond_hit) core_d.ip = tgt_now;
                    end
                    OP_CLEQ, OP_CLNE: begin
                        if (cond_hit) begin
                            mem_we     = 1'b1;
                            mem_addr   = core_q.rp - 16'd2;
                            mem_wdata  = core_q.ip[15:8];
                            core_d.rp  = core_q.rp - 16'd2;
                            core_d.tgt = tgt_now;
                            core_d.st  = S_PUSH_LO;
                        end
                    end
                    default: ;
                endcase
            end
            S_LOAD_WB: begin
                rf_we     = 1'b1;
                rf_wdata  = mem_rdata;
                core_d.st = S_FETCH;
            end
            S_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = core_q.rp + 16'd1;
                mem_wdata = core_q.ip[7:0];
                core_d.ip = core_q.tgt;
                core_d.st = S_FETCH;
            end
            S_RET_HI: begin
                core_d.tmp = mem_rdata;
                mem_re     = 1'b1;
                mem_addr   = core_q.rp + 16'd1;
                core_d.st  = S_RET_LO;
            end
            S_RET_LO: begin
                core_d.ip = {core_q.tmp, mem_rdata};
                core_d.rp = core_q.rp + 16'd2;
                core_d.st = S_FETCH;
            end
            S_HALT: ;
            default: core_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.st  <= S_IDLE;
            core_q.ip  <= IP_RESET;
            core_q.rp  <= RP_RESET;
            core_q.ir  <= '0;
            core_q.tmp <= '0;
            core_q.tgt <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign halted = (core_q.st == S_HALT);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_IDLE) |-> (!mem_re && !mem_we));

    assert_fetch_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_FETCH) |=> (core_q.ip == $past(core_q.ip) + 16'd1));

    assert_push_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_PUSH_LO) |-> (mem_we && $past(mem_we) &&
                                      mem_addr == $past(mem_addr) + 16'd1));

    assert_rp_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.rp[0] == RP_RESET[0]));

    assert_ret_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_RET_LO) |=> (core_q.rp == $past(core_q.rp) + 16'd2));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_re && !mem_we));

endmodule

// File: tb/byte_cpu_tb.sv
`timescale 1ns/1ps
module byte_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re, halted;
    logic [7:0]  mem_rdata = 8'h00;

    always #2 clk = ~clk;

    byte_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .halted(halted)
    );

    localparam logic [3:0] I_HALT = 4'h0, I_RET = 4'h1, I_SHL = 4'h2, I_SHR = 4'h3,
                           I_ROL = 4'h4, I_ROR = 4'h5, I_NAND = 4'h6, I_AND = 4'h7,
                           I_OR = 4'h8, I_XOR = 4'h9, I_LD = 4'hA, I_ST = 4'hB,
                           I_BEQ = 4'hC, I_BNE = 4'hD, I_CEQ = 4'hE, I_CNE = 4'hF;
    localparam logic [15:0] TERM = 16'hFFFF;

    typedef struct packed {
        logic        re;
        logic        we;
        logic        h;
        logic [15:0] a;
        logic [7:0]  d;
    } exp_t;

    int checks = 0, errors = 0;
    bit tracking = 0, finished = 0;
    logic [7:0] mem [int];
    logic [7:0] mm  [int];
    logic [7:0] tin[$], mtin[$], tout[$], mtout[$];
    exp_t  expq[$];
    string qtag[$];
    int    pc;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Environment memory: registered read, terminal at FFFF
    always @(posedge clk) begin
        if (mem_re) begin
            if (mem_addr == TERM) mem_rdata <= (tin.size() > 0) ? tin.pop_front() : 8'h00;
            else mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        end
        if (mem_we) begin
            if (mem_addr == TERM) tout.push_back(mem_wdata);
            else mem[int'(mem_addr)] = mem_wdata;
        end
    end

    // Per-cycle comparison against the expected bus trace
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (tracking) begin
            if (expq.size() > 0) begin
                e = expq.pop_front();
                t = qtag.pop_front();
            end else begin
                e = '0;
                e.h = 1'b1;
                t = "R11";
            end
            chk({mem_re, mem_we, halted} == {e.re, e.we, e.h}, t, "re/we/halted",
                {mem_re, mem_we, halted}, {e.re, e.we, e.h});
            if (e.re || e.we) chk(mem_addr == e.a, t, "address", mem_addr, e.a);
            if (e.we) chk(mem_wdata == e.d, t, "write data", mem_wdata, e.d);
        end
    end

    task automatic push(bit re, bit we, logic [15:0] a, logic [7:0] d, string tag);
        exp_t e;
        e.re = re; e.we = we; e.h = 1'b0; e.a = a; e.d = d;
        expq.push_back(e);
        qtag.push_back(tag);
    endtask

    function automatic logic [7:0] mrd(logic [15:0] a);
        if (a == TERM) return (mtin.size() > 0) ? mtin.pop_front() : 8'h00;
        return mm.exists(int'(a)) ? mm[int'(a)] : 8'h00;
    endfunction

    task automatic mwr(logic [15:0] a, logic [7:0] d);
        if (a == TERM) mtout.push_back(d);
        else mm[int'(a)] = d;
    endtask

    // Instruction-level model that emits the cycle trace from the requirements
    task automatic build_model();
        logic [15:0] ip, rp, a;
        logic [7:0]  r [4];
        logic [7:0]  op, hb;
        logic [1:0]  x, y;
        bit          done;
        int          steps;
        ip = 16'h0000; rp = 16'hFFF0; done = 0; steps = 0;
        for (int i = 0; i < 4; i++) r[i] = 8'h00;
        while (!done && steps < 500) begin
            steps++;
            push(1, 0, ip, 0, (steps == 1) ? "R1" : "R3");
            op = mrd(ip); ip = ip + 16'd1;
            x = op[3:2]; y = op[1:0];
            case (op[7:4])
                I_HALT: begin push(0, 0, 0, 0, "R11"); done = 1; end
                I_RET: begin
                    push(1, 0, rp, 0, "R10");
                    push(1, 0, rp + 16'd1, 0, "R10");
                    push(0, 0, 0, 0, "R10");
                    hb = mrd(rp);
                    ip = {hb, mrd(rp + 16'd1)};
                    rp = rp + 16'd2;
                end
                I_SHL:  begin r[x] = r[x] << 1; push(0, 0, 0, 0, "R4"); end
                I_SHR:  begin r[x] = r[x] >> 1; push(0, 0, 0, 0, "R4"); end
                I_ROL:  begin r[x] = {r[x][6:0], r[x][7]}; push(0, 0, 0, 0, "R5"); end
                I_ROR:  begin r[x] = {r[x][0], r[x][7:1]}; push(0, 0, 0, 0, "R5"); end
                I_NAND: begin r[x] = ~(r[x] & r[y]); push(0, 0, 0, 0, "R6"); end
                I_AND:  begin r[x] = r[x] & r[y]; push(0, 0, 0, 0, "R6"); end
                I_OR:   begin r[x] = r[x] | r[y]; push(0, 0, 0, 0, "R6"); end
                I_XOR:  begin r[x] = r[x] ^ r[y]; push(0, 0, 0, 0, "R6"); end
                default: begin
                    push(1, 0, ip, 0, "R2");
                    push(1, 0, ip + 16'd1, 0, "R2");
                    hb = mrd(ip);
                    a = {hb, mrd(ip + 16'd1)};
                    ip = ip + 16'd2;
                    case (op[7:4])
                        I_LD: begin
                            push(1, 0, a, 0, "R7");
                            push(0, 0, 0, 0, "R7");
                            r[x] = mrd(a);
                        end
                        I_ST: begin push(0, 1, a, r[x], "R7"); mwr(a, r[x]); end
                        I_BEQ, I_BNE: begin
                            push(0, 0, 0, 0, "R8");
                            if ((r[x] == r[y]) ^ op[4]) ip = a;
                        end
                        default: begin
                            if ((r[x] == r[y]) ^ op[4]) begin
                                push(0, 1, rp - 16'd2, ip[15:8], "R9");
                                push(0, 1, rp - 16'd1, ip[7:0], "R9");
                                mwr(rp - 16'd2, ip[15:8]);
                                mwr(rp - 16'd1, ip[7:0]);
                                rp = rp - 16'd2;
                                ip = a;
                            end else begin
                                push(0, 0, 0, 0, "R9");
                            end
                        end
                    endcase
                end
            endcase
        end
    endtask

    task automatic pb(logic [7:0] b);
        mem[pc] = b; pc++;
    endtask
    task automatic p1(logic [3:0] op, logic [1:0] x, logic [1:0] y);
        pb({op, x, y});
    endtask
    task automatic p3(logic [3:0] op, logic [1:0] x, logic [1:0] y, logic [15:0] a);
        pb({op, x, y}); pb(a[15:8]); pb(a[7:0]);
    endtask

    task automatic run_prog(int idle);
        int guard;
        tout.delete(); mtout.delete(); expq.delete(); qtag.delete();
        mtin = tin; mm = mem;
        build_model();
        rst_n = 0; start = 0;
        repeat (3) @(negedge clk);
        chk(!mem_re && !mem_we && !halted, "R1", "outputs in reset", {mem_re, mem_we, halted}, 0);
        rst_n = 1;
        repeat (idle) begin
            @(negedge clk);
            chk(!mem_re && !mem_we && !halted, "R1", "bus quiet before start",
                {mem_re, mem_we, halted}, 0);
        end
        start = 1;
        @(posedge clk);
        tracking = 1;
        guard = 0;
        while (expq.size() > 0 && guard < 4000) begin
            @(posedge clk);
            guard++;
        end
        if (guard >= 4000) chk(0, "R3", "trace not consumed", expq.size(), 0);
        repeat (3) @(negedge clk);
        start = 0;                              // R11: start toggling while halted
        repeat (3) @(negedge clk);
        start = 1;
        repeat (4) @(negedge clk);
        tracking = 0;
        chk(tout.size() == mtout.size(), "R7", "terminal byte count", tout.size(), mtout.size());
        for (int i = 0; i < mtout.size() && i < tout.size(); i++)
            chk(tout[i] == mtout[i], "R7", "terminal byte", tout[i], mtout[i]);
    endtask

    initial begin
        rst_n = 0; start = 0;

        // Program 1: loads, shifts, rotates, logic, stores, terminal
        mem.delete(); pc = 0;
        mem[16'h0100] = 8'h96; mem[16'h0101] = 8'h3C; mem[16'h0102] = 8'h81;
        p3(I_LD, 0, 0, 16'h0100); p3(I_LD, 1, 0, 16'h0101);
        p3(I_LD, 2, 0, 16'h0102); p3(I_LD, 3, 0, TERM);
        p1(I_SHL, 0, 0); p3(I_ST, 0, 0, TERM);
        p1(I_SHR, 0, 0); p3(I_ST, 0, 0, TERM);
        p1(I_ROL, 2, 0); p3(I_ST, 2, 0, 16'h0200);
        p1(I_ROR, 2, 0); p3(I_ST, 2, 0, 16'h0201);
        p1(I_ROR, 1, 0); p1(I_NAND, 1, 3); p3(I_ST, 1, 0, 16'h0202);
        p1(I_AND, 0, 3); p1(I_OR, 0, 2); p1(I_XOR, 0, 3); p3(I_ST, 0, 0, 16'h0204);
        p3(I_ST, 3, 0, TERM); p1(I_HALT, 0, 0);
        tin.delete(); tin.push_back(8'h5A);
        run_prog(5);
        if (tout.size() >= 3) begin
            chk(tout[0] == 8'h2C, "R4", "SHL 96 zero fill", tout[0], 8'h2C);
            chk(tout[1] == 8'h16, "R4", "SHR 2C zero fill", tout[1], 8'h16);
            chk(tout[2] == 8'h5A, "R7", "terminal echo", tout[2], 8'h5A);
        end else chk(0, "R7", "terminal output short", tout.size(), 3);
        chk(mem[16'h0200] == 8'h03, "R5", "ROL 81", mem[16'h0200], 8'h03);
        chk(mem[16'h0201] == 8'h81, "R5", "ROR 03", mem[16'h0201], 8'h81);
        chk(mem[16'h0202] == 8'hE5, "R6", "NAND 1E,5A", mem[16'h0202], 8'hE5);
        chk(mem[16'h0204] == 8'hC9, "R6", "AND/OR/XOR chain", mem[16'h0204], 8'hC9);

        // Program 2: branches both ways, calls, nested call, returns
        mem.delete(); pc = 0;
        mem[16'h0100] = 8'h05; mem[16'h0101] = 8'h05; mem[16'h0102] = 8'h07;
        p3(I_LD, 0, 0, 16'h0100); p3(I_LD, 1, 0, 16'h0101); p3(I_LD, 2, 0, 16'h0102);
        p3(I_BNE, 0, 1, 16'h0030);              // 0009 not taken
        p3(I_BEQ, 0, 1, 16'h0014);              // 000C taken
        pc = 16'h0014;
        p3(I_CEQ, 0, 2, 16'h0030);              // not taken
        p3(I_CNE, 0, 2, 16'h0040);              // 0017 taken, returns to 001A
        p3(I_ST, 2, 0, 16'h0203);
        p3(I_CEQ, 0, 1, 16'h0050);              // 001D taken, returns to 0020
        p1(I_HALT, 0, 0);
        pc = 16'h0030; p3(I_ST, 0, 0, TERM); p1(I_HALT, 0, 0);
        pc = 16'h0040; p3(I_ST, 0, 0, TERM); p1(I_RET, 0, 0);
        pc = 16'h0050; p3(I_CNE, 0, 2, 16'h0040); p1(I_RET, 0, 0);
        tin.delete();
        run_prog(2);
        chk(mem[16'h0203] == 8'h07, "R8", "code after branches reached", mem[16'h0203], 8'h07);
        chk({mem[16'hFFEE], mem[16'hFFEF]} == 16'h0020, "R9", "outer return address",
            {mem[16'hFFEE], mem[16'hFFEF]}, 16'h0020);
        chk({mem[16'hFFEC], mem[16'hFFED]} == 16'h0053, "R9", "nested return address",
            {mem[16'hFFEC], mem[16'hFFED]}, 16'h0053);
        chk(tout.size() == 2, "R10", "subroutine ran twice and returned", tout.size(), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule